// File: doc/BRIEF.md
# Grouped Daisy-Chain Interrupt Arbiter

This block arbitrates interrupt requests from peripherals that are organised in priority groups. Every group owns one shared request line, formed here as the OR of its members' requests. Groups have fixed ranks: group 0 ranks highest and the last group ranks lowest. The processor interrupt is raised only when the best pending group strictly outranks the level currently in service. This allows a higher group to nest over a handler that is already running.

When the processor acknowledges, the acknowledge enters the chain of the winning group and ripples past the members that are not requesting. It stops at the first member that is requesting, which is the one at the lowest position. The vector code of that member (its group and position) is registered and presented one cycle later. The acknowledged group's level is pushed onto an in-service stack. An end-of-interrupt strobe pops that stack and restores the level that was interrupted.

Top module: `irq_group_arbiter`

## Requirements
- R1: While reset is held, `cpu_irq`, `dev_ack`, `vec_valid` and `vec_code` are all zero and the in-service stack is empty.
- R2: Any request bit within a group activates that group's shared line. With nothing in service, `cpu_irq` is high in the same cycle as any request.
- R3: `cpu_irq` is high only when the lowest-numbered group with a pending request has a number strictly below the top in-service level. An empty stack counts as a level below every group. A request from a group equal to or below the top level keeps `cpu_irq` low.
- R4: A cycle with `cpu_ack` high and `cpu_irq` high drives exactly one `dev_ack` bit in that same cycle. It goes to the winning group's requesting device at the lowest position. Device bit index = group*N_DEV + position.
- R5: `cpu_ack` while `cpu_irq` is low produces no `dev_ack`, no vector and no change to the in-service state.
- R6: One cycle after a granted acknowledge, `vec_valid` pulses for one cycle. `vec_code` then holds group in bits [3:2] and position in bits [1:0], with the upper bits zero. `vec_code` keeps that value until the next grant.
- R7: A granted acknowledge pushes the winning group as the new in-service level, so only strictly higher groups can then interrupt.
- R8: `eoi` pops the most recent in-service level and restores the previous one. `eoi` on an empty stack has no effect.
- R9: When `eoi` and a granted acknowledge fall in the same cycle, the pop is applied first and the push second.
- R10: The stack depth never exceeds the number of groups. With all groups nested, no further request raises `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 16 | Per-device request, bit = group*4 + position |
| cpu_ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |
| dev_ack | output | 16 | Acknowledge delivered to each device |
| vec_valid | output | 1 | Vector code valid pulse |
| vec_code | output | 8 | Vector code {zeros, group, position} |

## Verification
A corrupted in-service stack shows first on `cpu_irq`. A wrong top level either blocks a group that should nest or admits one of equal or lower rank, and it does so in the very cycle the next request arrives. A broken pop appears on the first `eoi` that should reopen a blocked group. Chain faults appear on `dev_ack` in the acknowledge cycle itself, and encoding faults appear on `vec_code` exactly one cycle later. A cycle-accurate behavioural model therefore catches each fault within one cycle of the stimulus that exposes it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   function automatic int unsigned idx_w(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_group_prio.sv
module irq_group_prio #(
   parameter int unsigned N = 4,
   parameter int unsigned W = 2
) (
   input  logic [N-1:0] req,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
   parameter int unsigned N_DEV = 4,
   parameter int unsigned DW    = 2
) (
   input  logic             ack_in,
   input  logic [N_DEV-1:0] req,
   output logic [N_DEV-1:0] ack_out,
   output logic [DW-1:0]    pos
);
   logic [N_DEV-1:0] link;

   assign link[0] = ack_in;
   for (genvar i = 1; i < N_DEV; i++) begin : g_link
      assign link[i] = link[i-1] & ~req[i-1];
   end
   for (genvar i = 0; i < N_DEV; i++) begin : g_take
      assign ack_out[i] = link[i] & req[i];
   end

   always_comb begin
      pos = '0;
      for (int i = 0; i < N_DEV; i++) begin
         if (ack_out[i]) pos = pos | DW'(i);
      end
   end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned GW    = 2,
   parameter int unsigned CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [GW-1:0] push_lvl,
   output logic [CW-1:0] top_lvl,
   output logic [CW-1:0] depth
);
   logic [GW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt, cnt_popped;

   assign cnt_popped = (pop && cnt != '0) ? cnt - 1'b1 : cnt;
   assign depth      = cnt;
   assign top_lvl    = (cnt == '0) ? CW'(DEPTH) : CW'(mem[GW'(cnt - 1'b1)]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push && cnt_popped < CW'(DEPTH)) begin
            mem[GW'(cnt_popped)] <= push_lvl;
            cnt <= cnt_popped + 1'b1;
         end else begin
            cnt <= cnt_popped;
         end
      end
   end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter #(
   parameter int unsigned N_GRP = 4,
   parameter int unsigned N_DEV = 4,
   parameter int unsigned VEC_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_GRP*N_DEV-1:0] dev_req,
   input  logic                   cpu_ack,
   input  logic                   eoi,
   output logic                   cpu_irq,
   output logic [N_GRP*N_DEV-1:0] dev_ack,
   output logic                   vec_valid,
   output logic [VEC_W-1:0]       vec_code
);
   import irq_arb_pkg::*;

   localparam int unsigned GW = idx_w(N_GRP);
   localparam int unsigned DW = idx_w(N_DEV);
   localparam int unsigned CW = $clog2(N_GRP + 1);

   if (N_GRP < 2) begin : g_bad_grp
      $error("irq_group_arbiter: N_GRP must be at least 2");
   end
   if (VEC_W < GW + DW) begin : g_bad_vec
      $error("irq_group_arbiter: VEC_W too narrow for group and position");
   end

   logic [N_GRP-1:0] grp_line;
   logic [GW-1:0]    win;
   logic             any_req;
   logic [CW-1:0]    top_lvl, depth;
   logic             grant;
   logic [DW-1:0]    pos_g [N_GRP];
   logic [DW-1:0]    win_pos;

   for (genvar g = 0; g < N_GRP; g++) begin : g_line
      assign grp_line[g] = |dev_req[g*N_DEV +: N_DEV];
   end

   irq_group_prio #(.N(N_GRP), .W(GW)) u_prio (
      .req (grp_line),
      .idx (win),
      .any (any_req)
   );

   assign cpu_irq = any_req && (CW'(win) < top_lvl);
   assign grant   = cpu_ack && cpu_irq;

   for (genvar g = 0; g < N_GRP; g++) begin : g_chain
      irq_daisy_chain #(.N_DEV(N_DEV), .DW(DW)) u_chain (
         .ack_in  (grant && (win == GW'(g))),
         .req     (dev_req[g*N_DEV +: N_DEV]),
         .ack_out (dev_ack[g*N_DEV +: N_DEV]),
         .pos     (pos_g[g])
      );
   end

   assign win_pos = pos_g[win];

   irq_level_stack #(.DEPTH(N_GRP), .GW(GW), .CW(CW)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (grant),
      .pop      (eoi),
      .push_lvl (win),
      .top_lvl  (top_lvl),
      .depth    (depth)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_code  <= '0;
      end else begin
         vec_valid <= grant;
         if (grant) vec_code <= (VEC_W'(win) << DW) | VEC_W'(win_pos);
      end
   end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
   parameter int unsigned N_GRP = 4,
   parameter int unsigned N_DEV = 4,
   parameter int unsigned CW    = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_GRP*N_DEV-1:0] dev_req,
   input logic                   cpu_ack,
   input logic                   eoi,
   input logic                   cpu_irq,
   input logic [N_GRP*N_DEV-1:0] dev_ack,
   input logic                   vec_valid,
   input logic [CW-1:0]          depth
);
   assert_irq_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (dev_req != '0));
   assert_single_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack));
   assert_ack_to_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack & ~dev_req) == '0);
   assert_grant_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_irq) |-> $countones(dev_ack) == 1);
   assert_ignored_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !cpu_irq) |-> dev_ack == '0);
   assert_vec_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_irq) |=> vec_valid);
   assert_vec_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && cpu_irq) |=> !vec_valid);
   assert_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_irq && !eoi) |=> depth == $past(depth) + 1'b1);
   assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !cpu_ack && depth != '0) |=> depth == $past(depth) - 1'b1);
   assert_empty_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !cpu_ack && depth == '0) |=> depth == '0);
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CW'(N_GRP));
endmodule

bind irq_group_arbiter irq_arb_checker #(.N_GRP(N_GRP), .N_DEV(N_DEV), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_req   (dev_req),
   .cpu_ack   (cpu_ack),
   .eoi       (eoi),
   .cpu_irq   (cpu_irq),
   .dev_ack   (dev_ack),
   .vec_valid (vec_valid),
   .depth     (depth)
);

// File: tb/irq_group_arbiter_tb.sv
`timescale 1ns/1ps
module irq_group_arbiter_tb;
   localparam int NG = 4;
   localparam int ND = 4;
   localparam int NB = NG * ND;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] dev_req = '0;
   logic          cpu_ack = 1'b0;
   logic          eoi = 1'b0;
   logic          cpu_irq;
   logic [NB-1:0] dev_ack;
   logic          vec_valid;
   logic [7:0]    vec_code;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // behavioural reference state
   int            lvl_q[$];
   logic [NB-1:0] reqs = '0;
   logic          m_irq;
   logic [NB-1:0] m_ack;
   int            m_g, m_p;
   logic          m_vv = 1'b0;
   logic [7:0]    m_code = '0;

   always #2.5 clk = ~clk;

   irq_group_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack), .eoi(eoi),
      .cpu_irq(cpu_irq), .dev_ack(dev_ack), .vec_valid(vec_valid), .vec_code(vec_code)
   );

   task automatic model_comb(input logic a);
      int top;
      top = (lvl_q.size() == 0) ? NG : lvl_q[$];
      m_g = -1;
      m_p = 0;
      for (int g = NG - 1; g >= 0; g--) if (reqs[g*ND +: ND] != '0) m_g = g;
      m_irq = (m_g >= 0) && (m_g < top);
      m_ack = '0;
      if (a && m_irq) begin
         for (int p = ND - 1; p >= 0; p--) if (reqs[m_g*ND + p]) m_p = p;
         m_ack[m_g*ND + m_p] = 1'b1;
      end
   endtask

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic a, input logic e, input string tag);
      logic grant;
      dev_req = reqs;
      cpu_ack = a;
      eoi = e;
      #1;
      model_comb(a);
      cmp(tag, "cpu_irq", 32'(cpu_irq), 32'(m_irq));
      cmp(tag, "dev_ack", 32'(dev_ack), 32'(m_ack));
      cmp(tag, "vec_valid", 32'(vec_valid), 32'(m_vv));
      cmp(tag, "vec_code", 32'(vec_code), 32'(m_code));
      @(posedge clk);
      grant = a && m_irq && rst_n;
      if (rst_n) begin
         if (e && lvl_q.size() > 0) void'(lvl_q.pop_back());
         if (grant) lvl_q.push_back(m_g);
         m_vv = grant;
         if (grant) m_code = 8'((m_g << 2) | m_p);
         reqs = reqs & ~m_ack;   // acknowledged device drops its request
      end
      @(negedge clk);
      cpu_ack = 1'b0;
      eoi = 1'b0;
   endtask

   task automatic set_req(input int g, input int p);
      reqs[g*ND + p] = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset state
      repeat (3) cyc(1'b0, 1'b0, "R1");
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, "R1");
      // R5: acknowledge with nothing pending
      cyc(1'b1, 1'b0, "R5");
      cyc(1'b0, 1'b0, "R5");
      // R2: single request raises the line; R4/R6 grant and vector 0x0B
      set_req(2, 3);
      cyc(1'b0, 1'b0, "R2");
      cyc(1'b1, 1'b0, "R4");
      cyc(1'b0, 1'b0, "R6");
      // R3: lower and equal groups blocked while level 2 in service
      set_req(3, 0);
      cyc(1'b0, 1'b0, "R3");
      cyc(1'b1, 1'b0, "R5");
      set_req(2, 0);
      cyc(1'b0, 1'b0, "R3");
      set_req(1, 1);
      set_req(1, 3);
      cyc(1'b0, 1'b0, "R3");
      cyc(1'b1, 1'b0, "R4");
      cyc(1'b0, 1'b0, "R6");
      // R7: group 0 nests over group 1
      set_req(0, 2);
      cyc(1'b1, 1'b0, "R7");
      cyc(1'b0, 1'b0, "R7");
      // R8: unwind
      cyc(1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b0, "R8");
      // R9: eoi and grant together
      cyc(1'b1, 1'b1, "R9");
      cyc(1'b0, 1'b0, "R9");
      cyc(1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b0, "R8");
      // R10: full nesting 3,2,1,0 then no further irq
      repeat (6) cyc(1'b0, 1'b1, "R10");
      reqs = '0;
      for (int g = NG - 1; g >= 0; g--) begin
         set_req(g, 1);
         cyc(1'b1, 1'b0, "R10");
      end
      set_req(0, 0);
      cyc(1'b0, 1'b0, "R10");
      cyc(1'b1, 1'b0, "R10");
      cyc(1'b0, 1'b0, "R10");
      // R4: two groups pending, lower group number and lowest position win
      repeat (5) cyc(1'b0, 1'b1, "R4");
      reqs = '0;
      set_req(2, 1);
      set_req(0, 3);
      set_req(0, 1);
      cyc(1'b1, 1'b0, "R4");
      cyc(1'b0, 1'b0, "R6");
      // R7: random mix against the model
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 3) == 0) reqs[$urandom_range(0, NB-1)] = 1'b1;
         cyc(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 4) == 0), "R7");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule